// File: doc/BRIEF.md
# Upset-Tolerant Four-Phase Sequencer

This block is a small control sequencer with four phases: waiting, armed, running and finished. A start request moves it from waiting to armed. One cycle later it enters the running phase. It stays there for a fixed number of cycles, then spends a single cycle in the finished phase and returns to waiting. An abort request cuts the armed or running phase short. The block is meant for control paths where a radiation-induced bit flip in the phase register must not silently move the machine to a different legal phase.

The phase register holds redundant codes, and a parameter picks one of two protection levels. In the correcting level, the register is 5 bits wide and any two legal codes differ in at least three bit positions. Every code one bit away from a legal code is decoded as that legal phase. The machine therefore continues as if nothing had happened, writes the clean code back, and raises a one-cycle `corrected` pulse. Any other code is treated as waiting and raises a one-cycle `error` pulse. In the lighter detecting level, the register is 3 bits wide and the legal codes differ in at least two positions. Any illegal code sends the machine to waiting and raises `error`.

A test input XORs a mask into the phase register at the same clock edge that writes it. This lets a bench or a fault campaign plant an upset in any chosen cycle.

Top module: `ecc_sequencer`

## Requirements
- R1: In correcting mode (CORRECT=1) the waiting/armed/running/finished codes are 5'b00000, 5'b00111, 5'b11001, 5'b11110, and a held legal code reports its own phase on `phase` (0 waiting, 1 armed, 2 running, 3 finished) with no pulse. Exactly 4*(5+1)=24 of the 32 register values decode to a legal phase.
- R2: In correcting mode, each of the 20 codes at distance one from a legal code is reported as that legal phase, `corrected` is high for that cycle, and `error` stays low.
- R3: In correcting mode, a code that is neither legal nor at distance one from a legal code reports phase 0, raises `error` for that cycle, and the next transition is taken from waiting.
- R4: In detecting mode (CORRECT=0) the codes are 3'b000, 3'b011, 3'b101, 3'b110. Any odd-parity code reports phase 0 and raises `error`, and `corrected` is never raised.
- R5: From waiting, `start` gives armed on the next cycle. Armed always gives running one cycle later. Running lasts RUN_LEN cycles and is followed by one cycle of finished, then waiting.
- R6: `abort` in armed or running gives waiting on the next cycle. `abort` in waiting and `start` outside waiting have no effect.
- R7: `busy` is high exactly in armed and running. `done` is high exactly in the single finished cycle.
- R8: In correcting mode, a single-bit flip injected in any phase and any cycle leaves the `phase`, `busy` and `done` sequence identical to a fault-free run.
- R9: While `rst` is high the block reports phase 0 with `busy`, `done`, `corrected` and `error` low.
- R10: `corrected` and `error` are never high together, and each falls after one cycle unless a new upset is injected.
- R11: An `abort` in the last running cycle takes priority over completion: the next phase is waiting and `done` is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to leave waiting |
| abort | input | 1 | Cancel armed or running |
| fault_mask | input | W (5 or 3) | Bits XORed into the phase register at the write edge (test only, tie to zero) |
| phase | output | 2 | Decoded phase: 0 waiting, 1 armed, 2 running, 3 finished |
| busy | output | 1 | High in armed and running |
| done | output | 1 | One-cycle pulse in finished |
| corrected | output | 1 | A single-bit upset was repaired this cycle |
| error | output | 1 | An uncorrectable code was seen this cycle; machine is in waiting |

## Verification
The bench builds two instances side by side. The first uses CORRECT=1 with RUN_LEN=4; the 5-bit register makes every one of its 32 values reachable, so the whole neighbour map and the eight unrecoverable codes can be planted and checked. The second uses CORRECT=0 with RUN_LEN=3, which brings in the parity-style fallback to waiting and shows a run length different from the first. Both instances follow fault-free reference models on every cycle. Single-bit upsets are planted in each phase and on each bit to show that correction leaves the sequence unchanged, and that detection drops the machine to waiting.

// File: rtl/ecc_seq_pkg.sv
package ecc_seq_pkg;

    localparam int CODE_W_MAX = 5;
    localparam int N_PHASES   = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARM  = 2'd1,
        PH_RUN  = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        CL_EXACT = 2'd0,
        CL_NEAR  = 2'd1,
        CL_BAD   = 2'd2
    } class_e;

    typedef struct packed {
        phase_e phase;
        class_e kind;
    } decode_t;

    // Redundant codes; distance 3 when correcting, even parity when detecting.
    function automatic logic [CODE_W_MAX-1:0] code_of(input logic correct, input phase_e p);
        logic [CODE_W_MAX-1:0] c;
        if (correct) begin
            case (p)
                PH_IDLE: c = 5'b00000;
                PH_ARM:  c = 5'b00111;
                PH_RUN:  c = 5'b11001;
                default: c = 5'b11110;
            endcase
        end else begin
            case (p)
                PH_IDLE: c = 5'b00000;
                PH_ARM:  c = 5'b00011;
                PH_RUN:  c = 5'b00101;
                default: c = 5'b00110;
            endcase
        end
        return c;
    endfunction

    function automatic int unsigned bit_distance(input logic [CODE_W_MAX-1:0] a,
                                                 input logic [CODE_W_MAX-1:0] b);
        int unsigned d;
        d = 0;
        for (int k = 0; k < CODE_W_MAX; k++) begin
            if (a[k] != b[k]) d++;
        end
        return d;
    endfunction

    function automatic decode_t classify(input logic correct, input logic [CODE_W_MAX-1:0] code);
        decode_t r;
        int unsigned d;
        r.phase = PH_IDLE;
        r.kind  = CL_BAD;
        for (int i = 0; i < N_PHASES; i++) begin
            d = bit_distance(code, code_of(correct, phase_e'(i[1:0])));
            if (d == 0) begin
                r.phase = phase_e'(i[1:0]);
                r.kind  = CL_EXACT;
            end else if (correct && d == 1 && r.kind == CL_BAD) begin
                r.phase = phase_e'(i[1:0]);
                r.kind  = CL_NEAR;
            end
        end
        return r;
    endfunction

    function automatic phase_e step(input phase_e cur, input logic go,
                                    input logic stop, input logic expired);
        phase_e n;
        case (cur)
            PH_IDLE: n = go ? PH_ARM : PH_IDLE;
            PH_ARM:  n = stop ? PH_IDLE : PH_RUN;
            PH_RUN:  n = stop ? PH_IDLE : (expired ? PH_DONE : PH_RUN);
            default: n = PH_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ecc_seq_decoder.sv
module ecc_seq_decoder
    import ecc_seq_pkg::*;
#(
    parameter bit CORRECT = 1'b1,
    parameter int W       = 5
) (
    input  logic [W-1:0] code,
    output phase_e       phase,
    output class_e       kind
);

    logic [CODE_W_MAX-1:0] wide;
    decode_t               dec;

    always_comb begin
        wide         = '0;
        wide[W-1:0]  = code;
        dec          = classify(CORRECT, wide);
    end

    assign phase = dec.phase;
    assign kind  = dec.kind;

endmodule

// File: rtl/ecc_seq_timer.sv
module ecc_seq_timer #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic running,
    output logic expired
);

    localparam int            CW   = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
    localparam logic [CW-1:0] CAP  = CW'(RUN_LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            cnt <= '0;
        end else if (cnt < CAP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Greater-or-equal so an upset past the limit still terminates the run.
    assign expired = running && (cnt >= LAST);

endmodule

// File: rtl/ecc_seq_state_reg.sv
module ecc_seq_state_reg
    import ecc_seq_pkg::*;
#(
    parameter bit CORRECT = 1'b1,
    parameter int W       = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  phase_e       nxt,
    input  logic [W-1:0] flip,
    output logic [W-1:0] code
);

    localparam logic [CODE_W_MAX-1:0] RST_CODE = code_of(CORRECT, PH_IDLE);

    logic [CODE_W_MAX-1:0] enc;

    always_comb enc = code_of(CORRECT, nxt);

    // Clean code is always rewritten, which scrubs any repaired upset.
    always_ff @(posedge clk) begin
        if (rst) begin
            code <= RST_CODE[W-1:0];
        end else begin
            code <= enc[W-1:0] ^ flip;
        end
    end

endmodule

// File: rtl/ecc_sequencer.sv
module ecc_sequencer
    import ecc_seq_pkg::*;
#(
    parameter bit  CORRECT = 1'b1,
    parameter int  RUN_LEN = 4,
    localparam int W       = CORRECT ? 5 : 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         abort,
    input  logic [W-1:0] fault_mask,
    output logic [1:0]   phase,
    output logic         busy,
    output logic         done,
    output logic         corrected,
    output logic         error
);

    logic [W-1:0] sreg;
    phase_e       eff;
    class_e       kind;
    phase_e       nxt;
    logic         expired;

    ecc_seq_decoder #(.CORRECT(CORRECT), .W(W)) u_dec (
        .code  (sreg),
        .phase (eff),
        .kind  (kind)
    );

    ecc_seq_timer #(.RUN_LEN(RUN_LEN)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .running (eff == PH_RUN),
        .expired (expired)
    );

    always_comb nxt = step(eff, start, abort, expired);

    ecc_seq_state_reg #(.CORRECT(CORRECT), .W(W)) u_sreg (
        .clk  (clk),
        .rst  (rst),
        .nxt  (nxt),
        .flip (fault_mask),
        .code (sreg)
    );

    assign phase     = eff;
    assign busy      = (eff == PH_ARM) || (eff == PH_RUN);
    assign done      = (eff == PH_DONE);
    assign corrected = (kind == CL_NEAR);
    assign error     = (kind == CL_BAD);

endmodule

// File: rtl/ecc_sequencer_chk.sv
module ecc_sequencer_chk #(
    parameter bit CORRECT = 1'b1,
    parameter int W       = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         abort,
    input logic [W-1:0] fault_mask,
    input logic [1:0]   phase,
    input logic         busy,
    input logic         done,
    input logic         corrected,
    input logic         error
);

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(corrected && error));

    // R10
    corr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (corrected && fault_mask == '0) |=> !corrected);

    // R10
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (error && fault_mask == '0) |=> !error);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault_mask == '0) |=> !done);

    // R7
    busy_phase_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (phase == 2'd1 || phase == 2'd2));

    // R5
    start_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && start && fault_mask == '0) |=> (phase == 2'd1));

    // R6
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && abort && fault_mask == '0) |=> (phase == 2'd0));

    // R2
    single_fix_chk: assert property (@(posedge clk) disable iff (rst)
        (CORRECT && $countones(fault_mask) == 1) |=> (corrected && !error));

    // R4
    det_catch_chk: assert property (@(posedge clk) disable iff (rst)
        (!CORRECT && $countones(fault_mask) == 1) |=> (error && phase == 2'd0));

endmodule

bind ecc_sequencer ecc_sequencer_chk #(.CORRECT(CORRECT), .W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .abort      (abort),
    .fault_mask (fault_mask),
    .phase      (phase),
    .busy       (busy),
    .done       (done),
    .corrected  (corrected),
    .error      (error)
);

// File: tb/test_ecc_sequencer.sv
module test_ecc_sequencer;

    localparam int RL_C = 4;
    localparam int RL_D = 3;

    logic       clk    = 1'b0;
    logic       rst    = 1'b1;
    logic       start  = 1'b0;
    logic       abort  = 1'b0;
    logic [4:0] mask_c = '0;
    logic [2:0] mask_d = '0;

    logic [1:0] ph_c, ph_d;
    logic       busy_c, done_c, corr_c, err_c;
    logic       busy_d, done_d, corr_d, err_d;

    int n_run  = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit kill_c = 1'b0;
    bit kill_d = 1'b0;
    int c_st = 0, c_cnt = 0, d_st = 0, d_cnt = 0;

    int ccode[4] = '{0, 7, 25, 30};
    int dcode[4] = '{0, 3, 5, 6};

    always #4 clk = ~clk;

    ecc_sequencer #(.CORRECT(1'b1), .RUN_LEN(RL_C)) i_ecc_sequencer (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .fault_mask(mask_c),
        .phase(ph_c), .busy(busy_c), .done(done_c), .corrected(corr_c), .error(err_c)
    );

    ecc_sequencer #(.CORRECT(1'b0), .RUN_LEN(RL_D)) i_ecc_sequencer_det (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .fault_mask(mask_d),
        .phase(ph_d), .busy(busy_d), .done(done_d), .corrected(corr_d), .error(err_d)
    );

    // Fault-free reference model of the phase sequence
    function automatic int mnext(int st, int cnt, int rl, bit go, bit stop);
        case (st)
            0: return go ? 1 : 0;
            1: return stop ? 0 : 2;
            2: return stop ? 0 : ((cnt >= rl - 1) ? 3 : 2);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            c_st <= 0; c_cnt <= 0; d_st <= 0; d_cnt <= 0;
        end else begin
            c_st  <= kill_c ? 0 : mnext(c_st, c_cnt, RL_C, start, abort);
            c_cnt <= (c_st == 2) ? c_cnt + 1 : 0;
            d_st  <= kill_d ? 0 : mnext(d_st, d_cnt, RL_D, start, abort);
            d_cnt <= (d_st == 2) ? d_cnt + 1 : 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && cmp_en) begin
            chk(ph_c == c_st, "R5/R8 phase correcting", ph_c, c_st);
            chk(busy_c == (c_st == 1 || c_st == 2), "R7 busy correcting", busy_c, c_st);
            chk(done_c == (c_st == 3), "R7 done correcting", done_c, c_st);
            chk(ph_d == d_st, "R5 phase detecting", ph_d, d_st);
            chk(busy_d == (d_st == 1 || d_st == 2), "R7 busy detecting", busy_d, d_st);
            chk(done_d == (d_st == 3), "R7 done detecting", done_d, d_st);
        end
    end

    task automatic do_reset();
        cmp_en = 1'b0;
        rst = 1'b1; start = 1'b0; abort = 1'b0;
        mask_c = '0; mask_d = '0; kill_c = 1'b0; kill_d = 1'b0;
        repeat (2) @(negedge clk);
        chk(ph_c == 0 && ph_d == 0, "R9 phase in reset", ph_c, 0);
        chk(!busy_c && !busy_d && !done_c && !done_d, "R9 busy/done in reset", busy_c, 0);
        chk(!corr_c && !err_c && !corr_d && !err_d, "R9 flags in reset", err_c, 0);
        rst = 1'b0;
        cmp_en = 1'b1;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_sequence();
        do_reset();
        pulse_start();
        chk(ph_c == 1, "R5 armed after start", ph_c, 1);
        for (int i = 0; i < RL_C; i++) begin
            @(negedge clk);
            chk(ph_c == 2 && busy_c, "R5 running length", ph_c, 2);
        end
        @(negedge clk);
        chk(ph_c == 3 && done_c, "R7 finished pulse", ph_c, 3);
        @(negedge clk);
        chk(ph_c == 0 && !done_c, "R5 back to waiting", ph_c, 0);
    endtask

    task automatic t_abort();
        do_reset();
        pulse_start();
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(ph_c == 0, "R6 abort in armed", ph_c, 0);
        pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ph_c == 2, "R6 start ignored while running", ph_c, 2);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(ph_c == 0, "R6 abort in running", ph_c, 0);
        abort = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(ph_c == 0 && !busy_c, "R6 abort ignored in waiting", ph_c, 0);
        end
        abort = 1'b0;
    endtask

    task automatic t_abort_last();
        do_reset();
        pulse_start();
        while (!(c_st == 2 && c_cnt == RL_C - 1)) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(ph_c == 0 && !done_c, "R11 abort wins on last run cycle", ph_c, 0);
    endtask

    task automatic t_flip_correct();
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 5; b++) begin
                do_reset();
                if (p != 0) pulse_start();
                while (c_st != p) @(negedge clk);
                mask_c = 5'(1 << b);
                @(negedge clk);
                mask_c = '0;
                chk(corr_c == 1'b1, "R2 corrected pulse", corr_c, 1);
                chk(err_c == 1'b0, "R2 no error on single flip", err_c, 0);
                @(negedge clk);
                chk(corr_c == 1'b0, "R10 corrected falls", corr_c, 0);
                repeat (RL_C + 3) @(negedge clk);
            end
        end
    endtask

    task automatic t_flip_detect();
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 3; b++) begin
                do_reset();
                if (p != 0) pulse_start();
                while (d_st != p) @(negedge clk);
                mask_d = 3'(1 << b);
                kill_d = 1'b1;
                @(negedge clk);
                mask_d = '0;
                kill_d = 1'b0;
                chk(err_d == 1'b1 && ph_d == 0, "R4 flip drops to waiting", ph_d, 0);
                chk(corr_d == 1'b0, "R4 no correction when detecting", corr_d, 0);
                repeat (RL_D + 3) @(negedge clk);
            end
        end
    endtask

    task automatic t_double_flip();
        do_reset();
        pulse_start();
        mask_c = 5'b10100;
        kill_c = 1'b1;
        @(negedge clk);
        mask_c = '0;
        kill_c = 1'b0;
        chk(err_c == 1'b1 && ph_c == 0, "R3 uncorrectable code to waiting", ph_c, 0);
        chk(corr_c == 1'b0, "R3 no corrected pulse", corr_c, 0);
        @(negedge clk);
        chk(err_c == 1'b0, "R10 error falls", err_c, 0);
    endtask

    task automatic t_exhaustive();
        int n_good;
        int ep, kind, d;
        n_good = 0;
        do_reset();
        cmp_en = 1'b0;
        abort = 1'b1;
        for (int x = 0; x < 32; x++) begin
            mask_c = 5'(x);
            mask_d = (x < 8) ? 3'(x) : 3'd0;
            @(negedge clk);
            mask_c = '0;
            mask_d = '0;
            ep = 0; kind = 2;
            for (int s = 0; s < 4; s++) begin
                d = $countones(5'(x) ^ 5'(ccode[s]));
                if (d == 0) begin ep = s; kind = 0; end
                else if (d == 1 && kind == 2) begin ep = s; kind = 1; end
            end
            if (kind != 2) n_good++;
            chk(ph_c == ep, "R1/R2/R3 decoded phase", ph_c, ep);
            chk(corr_c == (kind == 1), "R2 corrected for neighbour", corr_c, kind);
            chk(err_c == (kind == 2), "R3 error for far code", err_c, kind);
            if (x < 8) begin
                ep = 0;
                for (int s = 0; s < 4; s++) if (dcode[s] == x) ep = s;
                chk(ph_d == ep, "R4 detecting decode", ph_d, ep);
                chk(err_d == ($countones(3'(x)) % 2 == 1), "R4 parity error", err_d, x);
                chk(corr_d == 1'b0, "R4 never corrected", corr_d, 0);
            end
        end
        abort = 1'b0;
        chk(n_good == 24, "R1 count of usable codes", n_good, 24);
    endtask

    bit finished = 1'b0;

    initial begin
        t_sequence();
        t_abort();
        t_abort_last();
        t_flip_correct();
        t_flip_detect();
        t_double_flip();
        t_exhaustive();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule